// File: doc/BRIEF.md
# Flash Erase and Program Status Reporter

This block stands in for the device side of a flash memory while an embedded program or erase operation runs. It holds a small byte array as the memory contents, a mask of the sectors chosen for erase, an operating mode (idle, programming, erasing, erase-suspended, failed) and a pulse counter that a tick input advances. When no operation runs, a read returns a byte from the array. During an operation, a read returns a status byte in its place.

The status byte carries three flags. A global toggle bit flips on every read while an operation is active. A sector toggle bit flips only on reads whose address falls in a sector marked for erase, and it keeps flipping during erase-suspend while the global bit holds. A timeout flag rises when a program runs out of pulses. Host-side polling code tells progress, suspend and failure apart by comparing two reads in a row.

The address splits into a sector number (upper bits) and a byte offset. Command decoding is outside the block: it receives one strobe per accepted command, with an operation code, a target address and data, and a sector mask.

Top module: `flash_erase_status`

## Requirements
- R1: After reset the block is idle, and a read at any address returns the erased value 0xFF one cycle after the read strobe.
- R2: A program command (op code 0) whose data only clears bits finishes on the PROG_PULSES-th tick. The array byte then holds old AND data, and later reads return array data.
- R3: From the first read after a command is accepted until the operation ends, a read at any address returns a status byte: bit 6 is the global toggle, bit 5 the timeout flag, bit 2 the sector toggle, and every other bit is 0. Bit 6 inverts between successive reads. Both toggles start at 0 after reset.
- R4: The sector toggle (bit 2) inverts only on reads whose sector, given by the upper address bits, is set in the erase mask. Reads in other sectors leave it unchanged.
- R5: An erase command (op code 1) with a non-empty mask finishes on the ERASE_PULSES-th tick. Every byte in a selected sector becomes 0xFF, other bytes are unchanged, and the mask clears.
- R6: A suspend request during erase stops the pulse counter. Reads in selected sectors then return status with bit 6 held and bit 2 still inverting. Reads in other sectors return array data. A resume request restarts counting from the held value.
- R7: A program that would turn a 0 bit into a 1 changes no data. On the PULSE_LIMIT-th tick the block enters a failed state. Status reads there show bit 5 set and bit 6 still inverting, and the counter never exceeds PULSE_LIMIT.
- R8: A reset command (op code 2) in the failed state returns the block to idle array reads with bit 5 cleared and the array unchanged.
- R9: The following are ignored: commands during program, erase or suspend; reset in idle; op code 3; an erase with an empty mask; suspend outside erase; resume outside suspend; ticks while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe for an accepted command |
| cmdOp | input | 2 | 0 program, 1 erase, 2 reset, 3 none |
| cmdAddr | input | ADDR_W | Byte address for program |
| cmdData | input | 8 | Program data |
| cmdSectMask | input | NUM_SECT | Sectors selected for erase |
| suspendReq | input | 1 | Erase-suspend request |
| resumeReq | input | 1 | Erase-resume request |
| pulseTick | input | 1 | Internal pulse tick |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Registered read result, array or status |

## Verification
The bench alternates reads between selected and unselected sectors. A design that flipped the sector toggle on every read, or that froze it during suspend, fails these comparisons. Ticks given during suspend are followed by exactly the remaining number of ticks needed to finish the erase, so a counter that kept running in suspend would end the erase early and return array data where status is expected. A program that tries to set a cleared bit is driven to the pulse limit and then reset. The bench then checks that the byte kept its old value, which exposes a design that wrote the bad data or lost the failure flag. It also sends stray commands during busy phases, which would corrupt the array or the mode in a design that accepted them.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_PROG  = 3'd1,
    MODE_ERASE = 3'd2,
    MODE_SUSP  = 3'd3,
    MODE_FAIL  = 3'd4
  } mode_e;

  localparam logic [1:0] OP_PROG  = 2'd0;
  localparam logic [1:0] OP_ERASE = 2'd1;
  localparam logic [1:0] OP_RESET = 2'd2;

  // Status byte bit positions read by host polling code
  localparam int BIT_GLOBAL = 6;
  localparam int BIT_FAIL   = 5;
  localparam int BIT_SECTOR = 2;

  typedef struct packed {
    logic capture;      // latch program address and data
    logic progCommit;   // write programmed byte
    logic eraseCommit;  // set selected sectors to erased
    logic flipGlobal;   // invert global toggle
    logic flipSector;   // invert sector toggle
    logic showStatus;   // this read returns status
    logic failFlag;     // timeout flag value
  } strobe_t;

endpackage

// File: rtl/fstat_ctrl.sv
module fstat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT     = 8,
  parameter int ADDR_W       = 5,
  parameter int PROG_PULSES  = 3,
  parameter int ERASE_PULSES = 6,
  parameter int PULSE_LIMIT  = 10,
  localparam int SECT_W      = $clog2(NUM_SECT),
  localparam int CNT_W       = $clog2(PULSE_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [NUM_SECT-1:0] cmdSectMask,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic                pulseTick,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                progBad,
  output strobe_t             stb,
  output mode_e               mode,
  output logic [CNT_W-1:0]    cnt,
  output logic [NUM_SECT-1:0] sectMask
);

  logic [SECT_W-1:0] rdSect;
  logic              selHit;
  logic [CNT_W-1:0]  cntNext;
  logic              tickLive, progEnd, eraseEnd, timeOut;
  logic              startProg, startErase, clearFail, activeRd;

  always_comb begin
    rdSect     = rdAddr[ADDR_W-1 -: SECT_W];
    selHit     = sectMask[rdSect];
    cntNext    = cnt + CNT_W'(1);
    tickLive   = pulseTick && (mode == MODE_PROG || mode == MODE_ERASE);
    progEnd    = tickLive && (mode == MODE_PROG) && !progBad &&
                 (cntNext == CNT_W'(PROG_PULSES));
    eraseEnd   = tickLive && (mode == MODE_ERASE) &&
                 (cntNext == CNT_W'(ERASE_PULSES));
    timeOut    = tickLive && !progEnd && !eraseEnd &&
                 (cntNext == CNT_W'(PULSE_LIMIT));
    startProg  = cmdValid && (mode == MODE_IDLE) && (cmdOp == OP_PROG);
    startErase = cmdValid && (mode == MODE_IDLE) && (cmdOp == OP_ERASE) &&
                 (|cmdSectMask);
    clearFail  = cmdValid && (mode == MODE_FAIL) && (cmdOp == OP_RESET);
    activeRd   = (mode == MODE_PROG) || (mode == MODE_ERASE) || (mode == MODE_FAIL);

    stb.capture     = startProg;
    stb.progCommit  = progEnd;
    stb.eraseCommit = eraseEnd;
    stb.flipGlobal  = rdEn && activeRd;
    stb.flipSector  = rdEn && selHit && (mode != MODE_IDLE);
    stb.showStatus  = rdEn && (activeRd || ((mode == MODE_SUSP) && selHit));
    stb.failFlag    = (mode == MODE_FAIL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      cnt      <= '0;
      sectMask <= '0;
    end else begin
      if (tickLive) cnt <= cntNext;
      unique case (mode)
        MODE_IDLE: begin
          if (startProg) begin
            mode <= MODE_PROG;
            cnt  <= '0;
          end else if (startErase) begin
            mode     <= MODE_ERASE;
            cnt      <= '0;
            sectMask <= cmdSectMask;
          end
        end
        MODE_PROG: begin
          if (progEnd)      mode <= MODE_IDLE;
          else if (timeOut) mode <= MODE_FAIL;
        end
        MODE_ERASE: begin
          if (eraseEnd) begin
            mode     <= MODE_IDLE;
            sectMask <= '0;
          end else if (timeOut) begin
            mode <= MODE_FAIL;
          end else if (suspendReq) begin
            mode <= MODE_SUSP;
          end
        end
        MODE_SUSP: begin
          if (resumeReq) mode <= MODE_ERASE;
        end
        MODE_FAIL: begin
          if (clearFail) begin
            mode     <= MODE_IDLE;
            sectMask <= '0;
          end
        end
        default: mode <= MODE_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fstat_dp.sv
module fstat_dp
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT = 8,
  parameter int ADDR_W   = 5,
  localparam int DEPTH   = 2 ** ADDR_W,
  localparam int BPS     = DEPTH / NUM_SECT
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [7:0]          cmdData,
  input  logic [NUM_SECT-1:0] sectMask,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic                progBad,
  output logic [7:0]          rdData
);

  logic [DEPTH-1:0][7:0] mem;
  logic [ADDR_W-1:0]     progAddrQ;
  logic [7:0]            progDataQ;
  logic                  togGlobal, togSector;
  logic [7:0]            statusByte;

  always_comb begin
    progBad    = |(progDataQ & ~mem[progAddrQ]);
    statusByte = '0;
    statusByte[BIT_GLOBAL] = togGlobal;
    statusByte[BIT_FAIL]   = stb.failFlag;
    statusByte[BIT_SECTOR] = togSector;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progAddrQ <= '0;
      progDataQ <= '0;
      togGlobal <= 1'b0;
      togSector <= 1'b0;
      rdData    <= '0;
    end else begin
      if (stb.capture) begin
        progAddrQ <= cmdAddr;
        progDataQ <= cmdData;
      end
      if (stb.flipGlobal) togGlobal <= ~togGlobal;
      if (stb.flipSector) togSector <= ~togSector;
      if (rdEn) rdData <= stb.showStatus ? statusByte : mem[rdAddr];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        mem[i] <= 8'hFF;
      end else if (stb.eraseCommit && sectMask[i / BPS]) begin
        mem[i] <= 8'hFF;
      end else if (stb.progCommit && (progAddrQ == ADDR_W'(i))) begin
        mem[i] <= mem[i] & progDataQ;
      end
    end
  end

endmodule

// File: rtl/flash_erase_status.sv
module flash_erase_status
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT     = 8,
  parameter int ADDR_W       = 5,
  parameter int PROG_PULSES  = 3,
  parameter int ERASE_PULSES = 6,
  parameter int PULSE_LIMIT  = 10,
  localparam int CNT_W       = $clog2(PULSE_LIMIT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [1:0]          cmdOp,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [7:0]          cmdData,
  input  logic [NUM_SECT-1:0] cmdSectMask,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic                pulseTick,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [7:0]          rdData
);

  strobe_t             stb;
  mode_e               mode;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_SECT-1:0] sectMask;
  logic                progBad;

  fstat_ctrl #(
    .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W), .PROG_PULSES(PROG_PULSES),
    .ERASE_PULSES(ERASE_PULSES), .PULSE_LIMIT(PULSE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdSectMask(cmdSectMask), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .pulseTick(pulseTick), .rdEn(rdEn), .rdAddr(rdAddr), .progBad(progBad),
    .stb(stb), .mode(mode), .cnt(cnt), .sectMask(sectMask)
  );

  fstat_dp #(
    .NUM_SECT(NUM_SECT), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .sectMask(sectMask), .rdEn(rdEn), .rdAddr(rdAddr), .progBad(progBad),
    .rdData(rdData)
  );

endmodule

// File: rtl/fstat_checker.sv
module fstat_checker
  import flash_stat_pkg::*;
#(
  parameter int NUM_SECT    = 8,
  parameter int PULSE_LIMIT = 10,
  localparam int CNT_W      = $clog2(PULSE_LIMIT + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [1:0]          cmdOp,
  input logic                resumeReq,
  input logic                rdEn,
  input logic [7:0]          rdData,
  input mode_e               mode,
  input logic [CNT_W-1:0]    cnt,
  input logic [NUM_SECT-1:0] sectMask
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(PULSE_LIMIT)); // R7

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SUSP && !resumeReq) |=> $stable(cnt)); // R6

  AST_FAIL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && mode == MODE_FAIL) |=> rdData[BIT_FAIL]); // R7

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_RESET && mode == MODE_FAIL) |=> (mode == MODE_IDLE)); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_PROG && cmdValid) |=> (mode != MODE_ERASE)); // R9

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDLE) |-> (sectMask == '0)); // R5

endmodule

bind flash_erase_status fstat_checker #(
  .NUM_SECT(NUM_SECT), .PULSE_LIMIT(PULSE_LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .resumeReq(resumeReq), .rdEn(rdEn), .rdData(rdData), .mode(mode),
  .cnt(cnt), .sectMask(sectMask)
);

// File: tb/tb_flash_erase_status.sv
`timescale 1ns/1ps
module tb_flash_erase_status;

  localparam int NS = 8, AW = 5, PP = 3, EP = 6, PL = 10;
  localparam int DEPTH = 2 ** AW, BPS = DEPTH / NS;

  logic clk = 0, rstN = 0, cmdValid = 0, suspendReq = 0, resumeReq = 0;
  logic pulseTick = 0, rdEn = 0;
  logic [1:0] cmdOp = 0;
  logic [AW-1:0] cmdAddr = 0, rdAddr = 0;
  logic [7:0] cmdData = 0, rdData;
  logic [NS-1:0] cmdSectMask = 0;

  int nTests = 0, nFail = 0;

  // Reference state built from the requirements
  logic [7:0] mArr [DEPTH];
  int mMode = 0, mCnt = 0, mPA = 0;
  logic [7:0] mPD;
  logic [NS-1:0] mMask = 0;
  bit mT6 = 0, mT2 = 0, mBad = 0;

  flash_erase_status #(.NUM_SECT(NS), .ADDR_W(AW), .PROG_PULSES(PP),
    .ERASE_PULSES(EP), .PULSE_LIMIT(PL)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .cmdSectMask(cmdSectMask),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .pulseTick(pulseTick),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData));

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, input string tag);
    logic [7:0] e;
    int s;
    bit hit, act;
    @(negedge clk); rdEn = 1; rdAddr = AW'(a);
    @(negedge clk); rdEn = 0;
    s = a / BPS; hit = mMask[s];
    act = (mMode == 1 || mMode == 2 || mMode == 4);
    if (act || (mMode == 3 && hit))
      e = {1'b0, mT6, (mMode == 4), 2'b00, mT2, 2'b00};
    else
      e = mArr[a];
    if (act) mT6 = ~mT6;
    if (hit && mMode != 0) mT2 = ~mT2;
    chk(tag, rdData, e);
  endtask

  task automatic cmd(input logic [1:0] op, input int a, input logic [7:0] d, input logic [NS-1:0] m);
    @(negedge clk); cmdValid = 1; cmdOp = op; cmdAddr = AW'(a); cmdData = d; cmdSectMask = m;
    @(negedge clk); cmdValid = 0;
    if (mMode == 0 && op == 2'd0) begin
      mPA = a; mPD = d; mBad = |(d & ~mArr[a]); mMode = 1; mCnt = 0;
    end else if (mMode == 0 && op == 2'd1 && m != 0) begin
      mMask = m; mMode = 2; mCnt = 0;
    end else if (mMode == 4 && op == 2'd2) begin
      mMode = 0; mMask = 0;
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); pulseTick = 1;
      @(negedge clk); pulseTick = 0;
      if (mMode == 1 || mMode == 2) begin
        mCnt++;
        if (mMode == 1 && !mBad && mCnt == PP) begin
          mArr[mPA] = mArr[mPA] & mPD; mMode = 0;
        end else if (mMode == 2 && mCnt == EP) begin
          for (int i = 0; i < DEPTH; i++) if (mMask[i / BPS]) mArr[i] = 8'hFF;
          mMask = 0; mMode = 0;
        end else if (mCnt == PL) begin
          mMode = 4;
        end
      end
    end
  endtask

  task automatic susp();
    @(negedge clk); suspendReq = 1;
    @(negedge clk); suspendReq = 0;
    if (mMode == 2) mMode = 3;
  endtask

  task automatic resume();
    @(negedge clk); resumeReq = 1;
    @(negedge clk); resumeReq = 0;
    if (mMode == 3) mMode = 2;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mArr[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: erased array after reset
    for (int a = 0; a < DEPTH; a++) rd(a, "R1");

    // R2/R3: program every byte, status during the operation
    for (int a = 0; a < DEPTH; a++) begin
      cmd(2'd0, a, 8'((a * 29) ^ 8'hC3), '0);
      rd(a ^ 7, "R3");
      rd(a, "R3");
      tick(PP);
      rd(a, "R2");
    end

    // R9: commands and suspend during program are ignored
    cmd(2'd0, 0, 8'h00, '0);
    cmd(2'd1, 0, 8'h00, '1);
    cmd(2'd2, 0, 8'h00, '0);
    susp();
    rd(3, "R9");
    tick(PP);
    rd(0, "R9");

    // R7: program that sets a cleared bit
    cmd(2'd0, 1, 8'hFF, '0);
    for (int k = 0; k < PL; k++) begin
      tick(1);
      rd(k, "R7");
    end
    @(negedge clk); rdEn = 1; rdAddr = 1;
    @(negedge clk); rdEn = 0; mT6 = ~mT6;
    chk("R7 timeout bit", rdData & 8'h20, 8'h20);
    cmd(2'd0, 2, 8'h00, '0);   // R9: ignored in failed state
    tick(2);
    rd(2, "R7");
    rd(2, "R7");
    // R8: leave failed state
    cmd(2'd2, 0, 8'h00, '0);
    rd(1, "R8");
    rd(2, "R8");

    // R4: sector toggle only for selected sectors
    cmd(2'd1, 0, 8'h00, 8'b0010_0110);
    rd(0, "R4"); rd(4, "R4"); rd(13, "R4"); rd(9, "R4");
    rd(31, "R4"); rd(21, "R4"); rd(2, "R4"); rd(6, "R4");
    tick(2);
    // R6: suspend holds counter and global toggle
    susp();
    rd(5, "R6"); rd(5, "R6"); rd(1, "R6"); rd(10, "R6"); rd(17, "R6"); rd(22, "R6");
    tick(3);
    cmd(2'd0, 16, 8'h00, '0);   // R9: ignored while suspended
    rd(16, "R9");
    resume();
    rd(7, "R6");
    tick(EP - 3);
    rd(12, "R6");
    tick(1);
    // R5: erase result
    for (int a = 0; a < DEPTH; a++) rd(a, "R5");

    // R5: second erase, ends and clears mask
    cmd(2'd1, 0, 8'h00, 8'b1000_0001);
    rd(0, "R4"); rd(28, "R4"); rd(14, "R4");
    tick(EP);
    for (int a = 0; a < DEPTH; a++) rd(a, "R5");

    // R9: ignored in idle
    cmd(2'd1, 0, 8'h00, '0);
    cmd(2'd3, 9, 8'h00, '1);
    cmd(2'd2, 0, 8'h00, '0);
    susp();
    resume();
    tick(4);
    for (int a = 0; a < DEPTH; a++) rd(a, "R9");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule